// File: doc/BRIEF.md
# JTAG Test Access Port with Selectable User Registers

This block is a JTAG test access port that a host processor drives over TCK, TMS, TDI and TDO to exchange 32-bit words with logic in the fabric. It contains the standard sixteen-state controller, a 10-bit instruction register, a one-bit bypass register and a bank of up to sixteen 32-bit user data registers.

Instruction decoding happens in two levels. A first instruction opens a short select register. Through that register the host writes an enable bit and a 4-bit index. A second instruction then routes TDI and TDO through the user register that the index names. In Capture-DR, that register loads a value from the fabric. In Update-DR, it hands the shifted-in word to a parallel output and raises a strobe for the fabric. Any other instruction, and any select value that is disabled, falls back to the bypass bit.

All state advances on the rising edge of TCK. TDO is updated on the falling edge, so it is stable when the host samples it. An optional active-low test reset puts the controller into Test-Logic-Reset asynchronously.

Top module: `jtag_user_tap`

## Requirements
- R1: From any state, five consecutive rising TCK edges with TMS high bring the controller to Test-Logic-Reset. In that state the instruction becomes bypass (all ones) and the select register is cleared to 0.
- R2: Capture-IR loads 10'b0101010101. A 10-bit IR scan therefore returns 0x155 on TDO, least significant bit first.
- R3: With bypass selected, a DR scan returns a 0 first and then TDI delayed by one bit. A host that sends a 32-bit value v reads back v shifted left by one.
- R4: Any instruction other than 0x00E (select) and 0x00C (data) acts as bypass.
- R5: Under instruction 0x00E, the DR path is a 5-bit select register: bit 4 is the enable, bits 3:0 are the index, shifted LSB first. Capture-DR loads the current select value, so it can be read back, and Update-DR stores the shifted value.
- R6: Under instruction 0x00C with the enable set and an index below NREG, Capture-DR loads that register's 32-bit slice of user_cap_i, and it shifts out LSB first.
- R7: Update-DR under R6 conditions writes the shifted word to the selected 32-bit slice of user_par_o. Other slices keep their values.
- R8: Each such Update-DR raises only the selected bit of user_upd_o, for exactly one TCK cycle.
- R9: Under instruction 0x00C with the select enable clear, the DR path is bypass, and no parallel output or strobe changes.
- R10: tdo_oe is high only while the controller is in Shift-IR or Shift-DR. Whenever tdo_oe is low, tdo reads 1. TDO changes only on the falling edge of TCK.
- R11: trst_n low asynchronously forces Test-Logic-Reset, clears all parallel outputs and strobes, and drives tdo high with tdo_oe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all JTAG logic runs on it |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| user_cap_i | input | NREG*DW | Parallel capture values, register k in bits k*DW+:DW |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | High while a shift state drives TDO |
| user_par_o | output | NREG*DW | Parallel outputs loaded in Update-DR, register k in bits k*DW+:DW |
| user_upd_o | output | NREG | One-cycle update strobe per user register |

## Verification
The assertions assume that TMS and TDI change only while TCK is low. They also assume that user_cap_i holds steady across the Capture-DR edge. The bench changes TMS and TDI only just after each falling edge, and it samples TDO a quarter period later. It fixes the capture values before reset is released and never changes them. Test reset is applied once, with TCK running, and released on a falling edge, so no property sees a release at the same time as a rising edge.

// File: rtl/jtag_user_tap.sv
module jtag_user_tap #(
  parameter int NREG = 16,
  parameter int DW = 32,
  parameter int IRW = 10,
  parameter int VIW = 4,
  parameter logic [IRW-1:0] IR_VSEL = 'h00E,
  parameter logic [IRW-1:0] IR_VDATA = 'h00C
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [NREG*DW-1:0] user_cap_i,
  output logic               tdo,
  output logic               tdo_oe,
  output logic [NREG*DW-1:0] user_par_o,
  output logic [NREG-1:0]    user_upd_o
);
  localparam int VRW = VIW + 1;
  localparam logic [IRW-1:0] IR_BYP = '1;
  localparam logic [IRW-1:0] IR_CAP = IRW'({(IRW+1)/2{2'b01}});

  typedef enum logic [3:0] {
    TLR = 4'hF, RTI = 4'hC, SELDR = 4'h7, CAPDR = 4'h6, SHDR = 4'h2, EX1DR = 4'h1,
    PAUDR = 4'h3, EX2DR = 4'h0, UPDDR = 4'h5, SELIR = 4'h4, CAPIR = 4'hE,
    SHIR = 4'hA, EX1IR = 4'h9, PAUIR = 4'hB, EX2IR = 4'h8, UPDIR = 4'hD
  } tap_e;

  tap_e             state_q, state_d;
  logic [IRW-1:0]   ir_q, ir_sh;
  logic [VRW-1:0]   vir_q, vir_sh;
  logic             byp_q, tdo_q, oe_q;
  logic [DW-1:0]    dr_sh;
  logic [DW-1:0]    par_q [NREG];
  logic [DW-1:0]    cap_arr [NREG];
  logic [NREG-1:0]  upd_q;
  logic [VIW-1:0]   idx;
  logic             sel_vsel, user_hit;

  for (genvar g = 0; g < NREG; g++) begin : g_slice
    assign cap_arr[g] = user_cap_i[g*DW +: DW];
    assign user_par_o[g*DW +: DW] = par_q[g];
  end

  assign idx      = vir_q[VIW-1:0];
  assign sel_vsel = (ir_q == IR_VSEL);
  assign user_hit = (ir_q == IR_VDATA) && vir_q[VIW] && (int'({1'b0, idx}) < NREG);

  always_comb begin
    case (state_q)
      TLR:     state_d = tms ? TLR : RTI;
      RTI:     state_d = tms ? SELDR : RTI;
      SELDR:   state_d = tms ? SELIR : CAPDR;
      CAPDR:   state_d = tms ? EX1DR : SHDR;
      SHDR:    state_d = tms ? EX1DR : SHDR;
      EX1DR:   state_d = tms ? UPDDR : PAUDR;
      PAUDR:   state_d = tms ? EX2DR : PAUDR;
      EX2DR:   state_d = tms ? UPDDR : SHDR;
      UPDDR:   state_d = tms ? SELDR : RTI;
      SELIR:   state_d = tms ? TLR : CAPIR;
      CAPIR:   state_d = tms ? EX1IR : SHIR;
      SHIR:    state_d = tms ? EX1IR : SHIR;
      EX1IR:   state_d = tms ? UPDIR : PAUIR;
      PAUIR:   state_d = tms ? EX2IR : PAUIR;
      EX2IR:   state_d = tms ? UPDIR : SHIR;
      UPDIR:   state_d = tms ? SELDR : RTI;
      default: state_d = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      state_q <= TLR;
      ir_q    <= IR_BYP;
      ir_sh   <= '0;
      vir_q   <= '0;
      vir_sh  <= '0;
      byp_q   <= 1'b0;
      dr_sh   <= '0;
      upd_q   <= '0;
      for (int k = 0; k < NREG; k++) par_q[k] <= '0;
    end else begin
      state_q <= state_d;
      upd_q   <= '0;
      case (state_q)
        TLR: begin
          ir_q  <= IR_BYP;
          vir_q <= '0;
        end
        CAPIR: ir_sh <= IR_CAP;
        SHIR:  ir_sh <= {tdi, ir_sh[IRW-1:1]};
        UPDIR: ir_q  <= ir_sh;
        CAPDR: begin
          byp_q <= 1'b0;
          if (sel_vsel) vir_sh <= vir_q;
          if (user_hit) dr_sh <= cap_arr[idx];
        end
        SHDR: begin
          byp_q  <= tdi;
          vir_sh <= {tdi, vir_sh[VRW-1:1]};
          dr_sh  <= {tdi, dr_sh[DW-1:1]};
        end
        UPDDR: begin
          if (sel_vsel) vir_q <= vir_sh;
          if (user_hit) begin
            par_q[idx] <= dr_sh;
            upd_q[idx] <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b1;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= (state_q == SHIR) || (state_q == SHDR);
      tdo_q <= (state_q == SHIR) ? ir_sh[0]
             : sel_vsel          ? vir_sh[0]
             : user_hit          ? dr_sh[0]
             : byp_q;
    end
  end

  assign tdo        = oe_q ? tdo_q : 1'b1;
  assign tdo_oe     = oe_q;
  assign user_upd_o = upd_q;
endmodule

// File: rtl/jtag_user_tap_chk.sv
module jtag_user_tap_chk #(
  parameter int NREG = 16,
  parameter int IRW = 10,
  parameter int VRW = 5
) (
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input logic            tdo,
  input logic            tdo_oe,
  input logic [NREG-1:0] user_upd_o,
  input logic [3:0]      state,
  input logic [IRW-1:0]  ir,
  input logic [VRW-1:0]  vir,
  input logic            hit
);
  localparam logic [3:0] S_TLR = 4'hF, S_SHDR = 4'h2, S_SHIR = 4'hA, S_UPDDR = 4'h5;
  logic [2:0] ones;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) ones <= '0;
    else ones <= tms ? ((ones == 3'd7) ? ones : ones + 3'd1) : 3'd0;
  end

  p_tms_reset_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (tms && ones >= 3'd4) |=> (state == S_TLR));

  p_tlr_clears_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_TLR) |=> (ir == '1 && vir == '0));

  p_strobe_onehot_r8: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0(user_upd_o));

  p_strobe_single_r8: assert property (@(posedge tck) disable iff (!trst_n)
    (|user_upd_o) |=> !(|user_upd_o));

  p_strobe_follows_update_r7: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_UPDDR && hit) |=> (|user_upd_o));

  p_oe_in_shift_r10: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == (state == S_SHDR || state == S_SHIR));

  p_idle_high_r10: assert property (@(posedge tck) disable iff (!trst_n)
    !tdo_oe |-> tdo);
endmodule

bind jtag_user_tap jtag_user_tap_chk #(.NREG(NREG), .IRW(IRW), .VRW(VIW + 1)) u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .tdo(tdo), .tdo_oe(tdo_oe),
  .user_upd_o(user_upd_o), .state(state_q), .ir(ir_q), .vir(vir_q), .hit(user_hit)
);

// File: tb/tb_jtag_user_tap.sv
module tb_jtag_user_tap;
  localparam int TCK_P = 20;
  localparam int NREG = 16;
  localparam int DW = 32;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [NREG*DW-1:0] user_cap_i;
  logic tdo, tdo_oe;
  logic [NREG*DW-1:0] user_par_o;
  logic [NREG-1:0] user_upd_o;
  int checks = 0, errors = 0;
  bit done = 0;

  jtag_user_tap dut (.*);

  always #(TCK_P/2) tck = ~tck;

  function automatic logic [31:0] cap_val(int k);
    return (32'h0101_0101 * (k + 1)) ^ 32'hC3C3_0000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck);
    tms = m;
    tdi = d;
    #(TCK_P/4);
    o = tdo;
    @(posedge tck);
    #1;
  endtask

  task automatic scan(input bit is_ir, input int n, input logic [31:0] v, output logic [31:0] r);
    logic o;
    r = '0;
    step(1, 0, o);
    if (is_ir) step(1, 0, o);
    step(0, 0, o);
    step(0, 0, o);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, v[i], o);
      r[i] = o;
    end
    step(1, 0, o);
    step(0, 0, o);
  endtask

  task automatic t_reset;
    logic o;
    chk("R11 tdo", {31'b0, tdo}, 32'd1);
    chk("R11 oe", {31'b0, tdo_oe}, 32'd0);
    chk("R11 upd", {16'b0, user_upd_o}, 32'd0);
    chk("R11 par3", user_par_o[3*DW +: DW], 32'd0);
    step(0, 0, o);
  endtask

  task automatic t_ir_capture;
    logic [31:0] r;
    scan(1, 10, 32'h3FF, r);
    chk("R2 capture pattern", r, 32'h155);
  endtask

  task automatic t_bypass;
    logic [31:0] r;
    scan(0, 32, 32'h00BC_614E, r);
    chk("R3 bypass delay", r, 32'h00BC_614E << 1);
    scan(1, 10, 32'h2A5, r);
    scan(0, 32, 32'hF0F0_1234, r);
    chk("R4 unknown code bypass", r, 32'hF0F0_1234 << 1);
  endtask

  task automatic t_pins;
    logic o;
    step(0, 0, o);
    chk("R10 idle tdo high", {31'b0, o}, 32'd1);
    chk("R10 idle oe low", {31'b0, tdo_oe}, 32'd0);
    step(1, 0, o);
    step(0, 0, o);
    step(0, 0, o);
    step(0, 0, o);
    chk("R10 oe in shift", {31'b0, tdo_oe}, 32'd1);
    step(1, 0, o);
    step(1, 0, o);
    step(0, 0, o);
  endtask

  task automatic t_select(input logic [4:0] sel);
    logic [31:0] r;
    scan(1, 10, 32'h00E, r);
    scan(0, 5, {27'b0, sel}, r);
    scan(0, 5, 32'h0, r);
    chk("R5 select readback", r, {27'b0, sel});
    scan(0, 5, {27'b0, sel}, r);
  endtask

  task automatic t_user_rw;
    logic [31:0] r;
    logic o;
    t_select(5'h13);
    scan(1, 10, 32'h00C, r);
    scan(0, 32, 32'hDEAD_BEEF, r);
    chk("R6 capture reg3", r, cap_val(3));
    chk("R8 strobe reg3", {16'b0, user_upd_o}, 32'h0008);
    chk("R7 par reg3", user_par_o[3*DW +: DW], 32'hDEAD_BEEF);
    chk("R7 par reg2 untouched", user_par_o[2*DW +: DW], 32'h0);
    step(0, 0, o);
    chk("R8 strobe one cycle", {16'b0, user_upd_o}, 32'h0);
    t_select(5'h1F);
    scan(1, 10, 32'h00C, r);
    scan(0, 32, 32'h1234_5678, r);
    chk("R6 capture reg15", r, cap_val(15));
    chk("R7 par reg15", user_par_o[15*DW +: DW], 32'h1234_5678);
    chk("R7 par reg3 kept", user_par_o[3*DW +: DW], 32'hDEAD_BEEF);
  endtask

  task automatic t_disabled;
    logic [31:0] r;
    t_select(5'h03);
    scan(1, 10, 32'h00C, r);
    scan(0, 32, 32'h0000_00FF, r);
    chk("R9 disabled bypass", r, 32'h0000_01FE);
    chk("R9 par reg3 kept", user_par_o[3*DW +: DW], 32'hDEAD_BEEF);
    chk("R9 no strobe", {16'b0, user_upd_o}, 32'h0);
  endtask

  task automatic t_tms_reset;
    logic [31:0] r;
    logic o;
    t_select(5'h15);
    scan(1, 10, 32'h00C, r);
    step(1, 0, o);
    step(0, 0, o);
    step(0, 0, o);
    for (int i = 0; i < 5; i++) step(1, 0, o);
    step(0, 0, o);
    scan(0, 32, 32'h0F00_0001, r);
    chk("R1 bypass after reset", r, 32'h1E00_0002);
    scan(1, 10, 32'h00E, r);
    scan(0, 5, 32'h0, r);
    chk("R1 select cleared", r, 32'h0);
  endtask

  initial begin
    for (int k = 0; k < NREG; k++) user_cap_i[k*DW +: DW] = cap_val(k);
    repeat (3) @(negedge tck);
    trst_n = 1'b1;
    #1;
    t_reset();
    t_ir_capture();
    t_bypass();
    t_pins();
    t_user_rw();
    t_disabled();
    t_tms_reset();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(TCK_P * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule